// File: doc/BRIEF.md
# Two-Stage Pipelined Multiply-Accumulator

The block keeps a running sum of signed products. On every clock it captures two signed operands into input registers. It multiplies the captured pair and adds the product to an accumulator, and the accumulator drives the output. A new operand pair can be presented on every cycle, so the block suits streaming dot-product or filter-tap work where one multiply-add per clock is needed.

In its default form the multiply and the add sit in separate pipeline stages, with a product register between them. Only the adder sits inside the feedback loop through the accumulator. Each product therefore joins the sum on the cycle after it is formed, and no stall or bubble is ever needed. The output stream equals that of a single-stage version of the same circuit, delayed by one cycle: one extra leading zero.

An elaboration parameter selects the single-stage datapath instead. That variant serves as a reference for comparing the two output streams.

Top module: `pipe_mac`

## Requirements
- R1: A synchronous, active-high reset clears the operand registers, the product register and the accumulator at the same clock edge. The output reads zero after that edge. Operands that were present before or during reset never reach the sum after reset is released.
- R2: With PIPELINED=1, the pair driven before clock edge n, counted from reset release, first affects the output after edge n+2. That is two edges after it is captured.
- R3: With PIPELINED=0, the pair driven before edge n first affects the output after edge n+1.
- R4: Operands are OP_W-bit two's complement values (default 8). The output equals the running sum of the sign-extended products of all pairs that have reached the adder.
- R5: With identical inputs, the pipelined output after edge n equals the single-stage output after edge n-1. The pipelined output after the first edge following reset is zero.
- R6: Operand pairs may change on every cycle without any gap. Every pair contributes exactly once, with no stall, bubble or dropped product. A pair in which either operand is zero leaves the output unchanged on the cycle it reaches the adder.
- R7: The accumulator is ACC_W bits wide (default 32) and wraps modulo 2^ACC_W on overflow.
- R8: The extreme operands give exact products: -128 x -128 = +16384, -128 x 127 = -16256, and 127 x 127 = 16129. A product of two nonzero operands of opposite sign is negative.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset of every register |
| op_a | input | OP_W | First signed operand, captured every cycle |
| op_b | input | OP_W | Second signed operand, captured every cycle |
| acc_out | output | ACC_W | Signed accumulator value |

## Verification
The bench runs a pipelined instance, a single-stage instance and a narrow 18-bit pipelined instance side by side. An impulse followed by zeros pins the latency of each variant. A design with the product register missing, or with an extra register, shifts the impulse by a cycle and breaks the one-cycle offset between the two streams. Back-to-back random pairs catch a design that drops or repeats a product. The extreme operand pairs catch unsigned or truncated multiplication, and a long run of -128 x -128 makes the narrow accumulator wrap, which catches saturating or mis-sized adders. A reset applied mid-stream while large operands are present catches any register that is left out of the reset and leaks a stale product into the fresh sum.

// File: rtl/pipe_mac_pkg.sv
package pipe_mac_pkg;

    // Datapath variant chosen at elaboration
    typedef enum logic {
        DP_SINGLE = 1'b0,
        DP_SPLIT  = 1'b1
    } dp_mode_e;

    // Full-precision product width for two signed operands
    function automatic int unsigned prod_width(input int unsigned op_w);
        return 2 * op_w;
    endfunction

endpackage

// File: rtl/pipe_mac_operand_reg.sv
module pipe_mac_operand_reg #(
    parameter int unsigned OP_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic signed [OP_W-1:0] a_in,
    input  logic signed [OP_W-1:0] b_in,
    output logic signed [OP_W-1:0] a_q,
    output logic signed [OP_W-1:0] b_q
);

    typedef struct packed {
        logic signed [OP_W-1:0] a;
        logic signed [OP_W-1:0] b;
    } ops_t;

    ops_t ops_d, ops_q;

    always_comb begin
        ops_d   = ops_q;
        ops_d.a = a_in;
        ops_d.b = b_in;
        if (rst) begin
            ops_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        ops_q <= ops_d;
    end

    assign a_q = ops_q.a;
    assign b_q = ops_q.b;

    // R1: captured operands are zero right after a reset edge
    p_ops_cleared_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (a_q == '0 && b_q == '0));

endmodule

// File: rtl/pipe_mac_mult.sv
module pipe_mac_mult
    import pipe_mac_pkg::*;
#(
    parameter int unsigned OP_W   = 8,
    parameter dp_mode_e    MODE   = DP_SPLIT,
    localparam int unsigned PROD_W = prod_width(OP_W)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [OP_W-1:0]   a,
    input  logic signed [OP_W-1:0]   b,
    output logic signed [PROD_W-1:0] prod
);

    logic signed [PROD_W-1:0] prod_raw;

    always_comb begin
        prod_raw = PROD_W'(a) * PROD_W'(b);
    end

    generate
        if (MODE == DP_SPLIT) begin : g_split
            typedef struct packed {
                logic signed [PROD_W-1:0] prod;
            } mst_t;

            mst_t mst_d, mst_q;

            always_comb begin
                mst_d      = mst_q;
                mst_d.prod = prod_raw;
                if (rst) begin
                    mst_d = '0;
                end
            end

            always_ff @(posedge clk) begin
                mst_q <= mst_d;
            end

            assign prod = mst_q.prod;

            // R1: the product register is cleared by reset
            p_prod_cleared_r1: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> (prod == '0));

            // R8: nonzero operands of opposite sign give a negative product
            p_prod_sign_r8: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(a != '0 && b != '0))
                |-> (prod[PROD_W-1] == $past(a[OP_W-1] ^ b[OP_W-1])));
        end else begin : g_single
            assign prod = prod_raw;
        end
    endgenerate

endmodule

// File: rtl/pipe_mac_accum.sv
module pipe_mac_accum #(
    parameter int unsigned PROD_W = 16,
    parameter int unsigned ACC_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [PROD_W-1:0] prod,
    output logic signed [ACC_W-1:0]  acc
);

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
    } ast_t;

    ast_t ast_d, ast_q;
    logic signed [ACC_W-1:0] prod_ext;

    always_comb begin
        prod_ext  = ACC_W'(prod);
        ast_d     = ast_q;
        ast_d.acc = ast_q.acc + prod_ext;
        if (rst) begin
            ast_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        ast_q <= ast_d;
    end

    assign acc = ast_q.acc;

    // R1: accumulator reads zero right after a reset edge
    p_acc_cleared_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (acc == '0));

endmodule

// File: rtl/pipe_mac.sv
module pipe_mac
    import pipe_mac_pkg::*;
#(
    parameter int unsigned OP_W      = 8,
    parameter int unsigned ACC_W     = 32,
    parameter bit          PIPELINED = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic signed [OP_W-1:0] op_a,
    input  logic signed [OP_W-1:0] op_b,
    output logic signed [ACC_W-1:0] acc_out
);

    localparam int unsigned PROD_W = prod_width(OP_W);
    localparam dp_mode_e    MODE   = PIPELINED ? DP_SPLIT : DP_SINGLE;

    logic signed [OP_W-1:0]   a_q;
    logic signed [OP_W-1:0]   b_q;
    logic signed [PROD_W-1:0] prod;

    pipe_mac_operand_reg #(
        .OP_W (OP_W)
    ) u_ops (
        .clk  (clk),
        .rst  (rst),
        .a_in (op_a),
        .b_in (op_b),
        .a_q  (a_q),
        .b_q  (b_q)
    );

    pipe_mac_mult #(
        .OP_W (OP_W),
        .MODE (MODE)
    ) u_mult (
        .clk  (clk),
        .rst  (rst),
        .a    (a_q),
        .b    (b_q),
        .prod (prod)
    );

    pipe_mac_accum #(
        .PROD_W (PROD_W),
        .ACC_W  (ACC_W)
    ) u_acc (
        .clk  (clk),
        .rst  (rst),
        .prod (prod),
        .acc  (acc_out)
    );

    // R6: a captured pair with a zero operand leaves the sum unchanged
    // when it reaches the adder (two edges later when split, one when not)
    generate
        if (PIPELINED) begin : g_chk_split
            p_zero_op_holds_r6: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && !$past(rst, 2) && $past(a_q == '0 || b_q == '0, 2))
                |-> (acc_out == $past(acc_out)));
        end else begin : g_chk_single
            p_zero_op_holds_r6: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(a_q == '0 || b_q == '0))
                |-> (acc_out == $past(acc_out)));
        end
    endgenerate

endmodule

// File: tb/pipe_mac_test.sv
module pipe_mac_test;

    localparam int CLK_PERIOD = 10;
    localparam int NARROW_W   = 18;
    localparam int HIST       = 1024;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [7:0] op_a = '0;
    logic signed [7:0] op_b = '0;
    logic signed [31:0] acc_pipe;
    logic signed [31:0] acc_ref;
    logic signed [NARROW_W-1:0] acc_narrow;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int n      = 0;
    int psum [0:HIST-1];
    logic signed [31:0] ref_prev;

    always #(CLK_PERIOD/2) clk = ~clk;

    pipe_mac #(.OP_W(8), .ACC_W(32), .PIPELINED(1'b1)) uut (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .acc_out(acc_pipe));

    pipe_mac #(.OP_W(8), .ACC_W(32), .PIPELINED(1'b0)) uut_ref (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .acc_out(acc_ref));

    pipe_mac #(.OP_W(8), .ACC_W(NARROW_W), .PIPELINED(1'b1)) uut_narrow (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .acc_out(acc_narrow));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, $signed(act), $signed(exp));
        end
    endtask

    function automatic int exp_at(input int k);
        return psum[(k < 0) ? 0 : k];
    endfunction

    task automatic clear_model();
        n        = 0;
        psum[0]  = 0;
        ref_prev = '0;
    endtask

    // Drive one pair, cross one edge, check all streams at the next falling edge
    task automatic step(input logic signed [7:0] a, input logic signed [7:0] b);
        logic [NARROW_W-1:0] nexp;
        if (n + 1 >= HIST) clear_model_by_reset();
        op_a = a;
        op_b = b;
        psum[n+1] = psum[n] + int'(a) * int'(b);
        ref_prev  = acc_ref;
        @(posedge clk);
        @(negedge clk);
        n++;
        check("R2 R4 pipelined sum", acc_pipe, exp_at(n - 2));
        check("R3 single-stage sum", acc_ref, exp_at(n - 1));
        check("R5 one-cycle offset", acc_pipe, ref_prev);
        nexp = exp_at(n - 2);
        check("R7 narrow wrap", 32'(acc_narrow) & ((32'd1 << NARROW_W) - 1), 32'(nexp));
    endtask

    task automatic do_reset(input int k);
        rst  = 1'b1;
        op_a = 8'sd90;
        op_b = -8'sd77;
        for (int i = 0; i < k; i++) begin
            @(posedge clk);
            @(negedge clk);
            check("R1 reset pipelined", acc_pipe, '0);
            check("R1 reset single", acc_ref, '0);
            check("R1 reset narrow", 32'(acc_narrow) & ((32'd1 << NARROW_W) - 1), '0);
        end
        rst = 1'b0;
        clear_model();
    endtask

    task automatic clear_model_by_reset();
        do_reset(1);
    endtask

    function automatic logic signed [7:0] rand_op();
        int unsigned r;
        r = $urandom % 10;
        if (r < 2) return 8'sd0;
        if (r == 2) return -8'sd128;
        if (r == 3) return 8'sd127;
        return 8'($urandom);
    endfunction

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'h5eed_cafe);
        @(negedge clk);
        do_reset(3);

        // R2 R3: impulse then zeros pins each latency
        step(8'sd5, -8'sd3);
        for (int i = 0; i < 4; i++) step(8'sd0, 8'sd0);
        check("R2 impulse reaches pipelined output", acc_pipe, -32'sd15);

        // R8: extreme operand pairs
        do_reset(1);
        step(-8'sd128, -8'sd128);
        step(-8'sd128, 8'sd127);
        step(8'sd127, 8'sd127);
        step(8'sd127, -8'sd128);
        step(8'sd0, 8'sd0);
        step(8'sd0, 8'sd0);
        check("R8 extreme products", acc_pipe, 32'sd16384 - 32'sd16256 + 32'sd16129 - 32'sd16256);

        // R6: back-to-back random pairs, no gaps
        for (int i = 0; i < 400; i++) step(rand_op(), rand_op());

        // R7: drive the narrow accumulator across its range
        do_reset(1);
        for (int i = 0; i < 24; i++) step(-8'sd128, -8'sd128);
        step(8'sd0, 8'sd0);
        step(8'sd0, 8'sd0);
        check("R7 wide accumulator holds exact sum", acc_pipe, 32'sd16384 * 24);

        // R1: reset mid-stream with large operands present, then zeros
        step(8'sd100, 8'sd100);
        step(8'sd99, -8'sd99);
        do_reset(1);
        for (int i = 0; i < 4; i++) step(8'sd0, 8'sd0);
        check("R1 no stale product after reset", acc_pipe, '0);

        // R6: alternating zero and nonzero pairs, then more random
        for (int i = 0; i < 60; i++) begin
            if (i % 2 == 0) step(8'sd0, rand_op());
            else step(rand_op(), rand_op());
        end
        for (int i = 0; i < 300; i++) step(rand_op(), rand_op());

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule